// File: doc/BRIEF.md
# GPIO Output Control Slice

This block holds the output side of a general-purpose I/O port. It keeps one internal output-value word and one internal output-enable word, and it drives both words straight onto the per-pin output and output-enable lines. Software reaches these two words through a small register port. A direct register replaces a whole word. A masked register changes only chosen bits of the lower half or of the upper half of a word, so two agents can share the port without a read-modify-write.

The block also holds an input-data register. It samples the level present on each pin. On a pin whose enable is set, that level is the value the block drives. On a pin whose enable is clear, that level is the externally applied value. This register is read-only.

The register port is single-cycle. A write takes effect at the clock edge where `reg_we_i` is high. Read data is combinational from `reg_addr_i`.

Top module: `gpio_outctl`

## Requirements
- R1: While reset is active and after it is released, `gpio_o` and `gpio_oe_o` are all zero, and reads of the direct registers return zero.
- R2: A write to the direct-value register (address 1) loads the full value word at the clock edge of the write. Reading address 1 returns the whole word.
- R3: A write to the direct-enable register (address 4) loads the full enable word. Reading address 4 returns the whole word.
- R4: A write to masked-value-lower (address 2) uses bits 31:16 as a mask and bits 15:0 as data. Only value bits 15:0 whose mask bit is 1 take the data. Every other value bit is unchanged, including all of pins 31:16.
- R5: A write to masked-value-upper (address 3) uses the same layout as R4, but acts on pins 31:16. Pins 15:0 are unchanged.
- R6: Masked-enable-lower (address 5) and masked-enable-upper (address 6) apply the rules of R4 and R5 to the enable word.
- R7: A read of any masked register (addresses 2, 3, 5, 6) returns 0 in bits 31:16. Bits 15:0 hold the current value of that half of the word it targets.
- R8: Input data (address 0) shows, one cycle after the pin state, the driven value on each enabled pin and `gpio_i` on each disabled pin.
- R9: A write to address 0 has no effect. The value word, the enable word and the input sampling all continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| gpio_i | input | 32 | Externally applied pin levels |
| gpio_o | output | 32 | Per-pin output value |
| gpio_oe_o | output | 32 | Per-pin output enable |

## Verification
The bench builds the block with the default 32 pins. At that width each masked register has a full 16-bit mask over a 16-bit half, and both halves are present, so one half can be checked for staying untouched while the other is written. Random masks, data and pin levels give a mix of enabled and disabled pins. With that mix, input-data readback is checked against both the driven value and the applied pin value in the same word.

// File: rtl/gpio_outctl_pkg.sv
package gpio_outctl_pkg;
  typedef enum logic [2:0] {
    A_DIN     = 3'd0,
    A_DOUT    = 3'd1,
    A_MOUT_LO = 3'd2,
    A_MOUT_HI = 3'd3,
    A_DOE     = 3'd4,
    A_MOE_LO  = 3'd5,
    A_MOE_HI  = 3'd6
  } gpio_addr_e;

  typedef struct packed {
    logic full;
    logic lo;
    logic hi;
  } wr_sel_t;
endpackage

// File: rtl/gpio_shadow_word.sv
module gpio_shadow_word
  import gpio_outctl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  wr_sel_t      sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] word_o
);
  localparam int H = W / 2;

  logic [W-1:0] word_q, word_d;
  logic [H-1:0] mask, data;

  assign mask = wdata_i[W-1:H];
  assign data = wdata_i[H-1:0];

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic half_sel;
    assign half_sel = (h == 0) ? sel_i.lo : sel_i.hi;
    always_comb begin
      if (sel_i.full)    word_d[h*H +: H] = wdata_i[h*H +: H];
      else if (half_sel) word_d[h*H +: H] = (mask & data) | (~mask & word_q[h*H +: H]);
      else               word_d[h*H +: H] = word_q[h*H +: H];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= word_d;
  end

  assign word_o = word_q;

  assert_direct_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i.full |=> word_q == $past(wdata_i));

  assert_lo_keeps_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i.lo && !sel_i.full) |=> word_q[W-1:H] == $past(word_q[W-1:H]));

  assert_lo_unmasked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i.lo && !sel_i.full) |=>
      ((word_q[H-1:0] ^ $past(word_q[H-1:0])) & ~$past(wdata_i[W-1:H])) == '0);

  assert_hi_keeps_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i.hi && !sel_i.full) |=> word_q[H-1:0] == $past(word_q[H-1:0]));

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i.full || sel_i.lo || sel_i.hi) |=> $stable(word_q));
endmodule

// File: rtl/gpio_in_sample.sv
module gpio_in_sample #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] out_i,
  input  logic [W-1:0] oe_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] din_o
);
  logic [W-1:0] din_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) din_q <= '0;
    else         din_q <= (oe_i & out_i) | (~oe_i & pin_i);
  end

  assign din_o = din_q;

  assert_driven_seen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((din_o ^ $past(out_i)) & $past(oe_i)) == '0);

  assert_external_seen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((din_o ^ $past(pin_i)) & ~$past(oe_i)) == '0);
endmodule

// File: rtl/gpio_outctl.sv
module gpio_outctl
  import gpio_outctl_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [NPINS-1:0] reg_wdata_i,
  output logic [NPINS-1:0] reg_rdata_o,
  input  logic [NPINS-1:0] gpio_i,
  output logic [NPINS-1:0] gpio_o,
  output logic [NPINS-1:0] gpio_oe_o
);
  localparam int H = NPINS / 2;

  wr_sel_t          out_sel, oe_sel;
  logic [NPINS-1:0] out_w, oe_w, din_w;
  gpio_addr_e       addr;

  assign addr = gpio_addr_e'(reg_addr_i);

  always_comb begin
    out_sel.full = reg_we_i && (addr == A_DOUT);
    out_sel.lo   = reg_we_i && (addr == A_MOUT_LO);
    out_sel.hi   = reg_we_i && (addr == A_MOUT_HI);
    oe_sel.full  = reg_we_i && (addr == A_DOE);
    oe_sel.lo    = reg_we_i && (addr == A_MOE_LO);
    oe_sel.hi    = reg_we_i && (addr == A_MOE_HI);
  end

  gpio_shadow_word #(.W(NPINS)) u_out_word (
    .clk_i, .rst_ni, .sel_i(out_sel), .wdata_i(reg_wdata_i), .word_o(out_w)
  );

  gpio_shadow_word #(.W(NPINS)) u_oe_word (
    .clk_i, .rst_ni, .sel_i(oe_sel), .wdata_i(reg_wdata_i), .word_o(oe_w)
  );

  gpio_in_sample #(.W(NPINS)) u_in_sample (
    .clk_i, .rst_ni, .out_i(out_w), .oe_i(oe_w), .pin_i(gpio_i), .din_o(din_w)
  );

  always_comb begin
    unique case (addr)
      A_DIN:     reg_rdata_o = din_w;
      A_DOUT:    reg_rdata_o = out_w;
      A_MOUT_LO: reg_rdata_o = {{H{1'b0}}, out_w[H-1:0]};
      A_MOUT_HI: reg_rdata_o = {{H{1'b0}}, out_w[NPINS-1:H]};
      A_DOE:     reg_rdata_o = oe_w;
      A_MOE_LO:  reg_rdata_o = {{H{1'b0}}, oe_w[H-1:0]};
      A_MOE_HI:  reg_rdata_o = {{H{1'b0}}, oe_w[NPINS-1:H]};
      default:   reg_rdata_o = '0;
    endcase
  end

  assign gpio_o    = out_w;
  assign gpio_oe_o = oe_w;

  assert_din_write_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd0) |=> $stable(gpio_o) && $stable(gpio_oe_o));

  assert_oe_direct_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 3'd4) |=> gpio_oe_o == $past(reg_wdata_i));
endmodule

// File: tb/gpio_outctl_bench.sv
module gpio_outctl_bench;
  localparam int W = 32;
  localparam int H = 16;

  logic         clk_i = 0;
  logic         rst_ni = 0;
  logic         reg_we_i = 0;
  logic [2:0]   reg_addr_i = 0;
  logic [W-1:0] reg_wdata_i = 0;
  logic [W-1:0] reg_rdata_o;
  logic [W-1:0] gpio_i = 0;
  logic [W-1:0] gpio_o, gpio_oe_o;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  logic [W-1:0] m_out = 0, m_oe = 0, m_din = 0;

  always #5 clk_i = ~clk_i;

  gpio_outctl u_gpio_outctl (.*);

  function automatic logic [H-1:0] merge(logic [H-1:0] cur, logic [W-1:0] wd);
    return (wd[W-1:H] & wd[H-1:0]) | (~wd[W-1:H] & cur);
  endfunction

  function automatic logic [W-1:0] model_read(logic [2:0] a);
    case (a)
      3'd0: return m_din;
      3'd1: return m_out;
      3'd2: return {16'h0, m_out[15:0]};
      3'd3: return {16'h0, m_out[31:16]};
      3'd4: return m_oe;
      3'd5: return {16'h0, m_oe[15:0]};
      3'd6: return {16'h0, m_oe[31:16]};
      default: return '0;
    endcase
  endfunction

  function automatic string read_req(logic [2:0] a);
    case (a)
      3'd0: return "R8";
      3'd1: return "R2";
      3'd4: return "R3";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic op(bit we, logic [2:0] a, logic [W-1:0] wd, logic [W-1:0] pins, string wreq);
    @(negedge clk_i);
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd; gpio_i = pins;
    #1;
    chk(read_req(a), reg_rdata_o, model_read(a));
    @(posedge clk_i);
    m_din = (m_oe & m_out) | (~m_oe & pins);
    if (we) begin
      case (a)
        3'd1: m_out = wd;
        3'd2: m_out[15:0] = merge(m_out[15:0], wd);
        3'd3: m_out[31:16] = merge(m_out[31:16], wd);
        3'd4: m_oe = wd;
        3'd5: m_oe[15:0] = merge(m_oe[15:0], wd);
        3'd6: m_oe[31:16] = merge(m_oe[31:16], wd);
        default: ;
      endcase
    end
    #1;
    chk(wreq, gpio_o, m_out);
    chk(wreq, gpio_oe_o, m_oe);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1", gpio_o, '0);
    chk("R1", gpio_oe_o, '0);
    @(negedge clk_i);
    rst_ni = 1;
    op(0, 3'd1, '0, '0, "R1");
    op(0, 3'd4, '0, '0, "R1");
    // R2/R3 full loads
    op(1, 3'd1, 32'hA5A5_3C3C, '0, "R2");
    op(1, 3'd4, 32'hFFFF_0000, 32'h1234_5678, "R3");
    op(0, 3'd0, '0, 32'h0F0F_F0F0, "R8");
    op(0, 3'd0, '0, 32'h0F0F_F0F0, "R8");
    // R4 lower masked: only mask bits update
    op(1, 3'd2, 32'h00FF_1234, '0, "R4");
    op(0, 3'd2, '0, '0, "R7");
    // R5 upper masked
    op(1, 3'd3, 32'hF000_0000, '0, "R5");
    op(1, 3'd3, 32'h0000_FFFF, '0, "R5");
    op(0, 3'd3, '0, '0, "R7");
    // R6 masked enables
    op(1, 3'd5, 32'hFFFF_00FF, '0, "R6");
    op(1, 3'd6, 32'h0F0F_FFFF, '0, "R6");
    op(0, 3'd5, '0, '0, "R7");
    op(0, 3'd6, '0, '0, "R7");
    // R9 write to input data ignored
    op(1, 3'd0, 32'hFFFF_FFFF, 32'hDEAD_BEEF, "R9");
    op(0, 3'd0, '0, 32'hDEAD_BEEF, "R9");
    op(0, 3'd0, '0, '0, "R9");
    // R8 all inputs: clear enables
    op(1, 3'd4, '0, 32'hCAFE_F00D, "R3");
    op(0, 3'd0, '0, 32'hCAFE_F00D, "R8");
    op(0, 3'd0, '0, 32'h1111_2222, "R8");
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [2:0] a;
      bit we;
      string rq;
      a = 3'($urandom_range(0, 6));
      we = bit'($urandom_range(0, 1));
      case (a)
        3'd0: rq = "R9";
        3'd1: rq = "R2";
        3'd2: rq = "R4";
        3'd3: rq = "R5";
        3'd4: rq = "R3";
        default: rq = "R6";
      endcase
      op(we, a, $urandom(), $urandom(), we ? rq : "R8");
    end
    finish_run();
  end
endmodule